// File: doc/BRIEF.md
# Receive Virtual-Channel Status Tracker

Several virtual receive channels share one packet FIFO. This block follows the receive side of those channels from a stream of event strobes. Each strobe carries a channel index. Software posting a receive descriptor makes a channel busy. The receive engine handing the next FIFO packet to a channel makes that channel mapped. A finished copy either consumes the rest of the packet or leaves a remainder behind. A channel holding a packet that has been copied in part is dirty. Three saturating counters sum up how many channels are busy, mapped and dirty. The block packs those counters, together with a head field, into one 64-bit status word that software reads. The head field names the channel that stalls the FIFO because its oldest packet is only partly copied.

The receive scheduler also reports, for each copy it schedules, how many packets the chosen channel's packet sits behind the FIFO head. The block adds these distances into a running total, counts the samples and tracks the largest value seen. A statistics clear strobe resets only the maximum. Packet storage and the DMA engine sit outside this block.

Top module: `rx_vc_tracker`

## Requirements
- R1: After reset all counters, per-channel offsets and statistics are zero, and the status word reads 64'h0000_0000_0000_FFFF.
- R2: A descriptor-write strobe adds one to the busy count in the following cycle. A copy-done strobe subtracts one from it.
- R3: A map strobe adds one to the mapped count and sets the addressed channel's copy offset to zero.
- R4: A copy-done with the full flag set subtracts one from the mapped count and returns the channel's offset to zero. If the offset was nonzero beforehand, it also subtracts one from the dirty count.
- R5: A copy-done with the full flag clear advances the channel's offset by the copied length. It adds one to the dirty count only when the offset was zero before that copy.
- R6: The status word is {dirty[15:0], mapped[15:0], busy[15:0], head[15:0]}, with dirty in bits 63:48 and head in bits 15:0.
- R7: The head field is the zero-extended channel index captured with the head-valid strobe when that channel's offset, after the same cycle's updates, is nonzero. In every other case it reads 16'hFFFF.
- R8: Each schedule strobe adds its distance to a 32-bit total and adds one to a 32-bit sample count, both saturating. It also raises the maximum distance when the new distance is larger.
- R9: A statistics-clear strobe zeroes the maximum distance and leaves the total and the sample count unchanged. If a schedule strobe arrives in the same cycle, the maximum becomes that strobe's distance.
- R10: The busy count holds at 16'hFFFF once it gets there and never wraps to zero.
- R11: Events on different channels in the same cycle combine. A descriptor write together with a copy-done leaves the busy count unchanged. A map together with a full copy-done leaves the mapped count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_wr_i | input | 1 | Receive descriptor written |
| desc_ch_i | input | CH_W | Channel of the descriptor write |
| map_i | input | 1 | Next FIFO packet mapped to a channel |
| map_ch_i | input | CH_W | Channel receiving the packet |
| done_i | input | 1 | Copy finished |
| done_ch_i | input | CH_W | Channel whose copy finished |
| done_full_i | input | 1 | 1: the whole remainder was copied |
| done_len_i | input | LEN_W | Bytes moved by this copy |
| head_vld_i | input | 1 | Oldest FIFO packet belongs to a channel |
| head_ch_i | input | CH_W | Owner of the oldest FIFO packet |
| sched_i | input | 1 | A channel was scheduled for a copy |
| sched_dist_i | input | DIST_W | Packets ahead of that channel's packet |
| stat_clr_i | input | 1 | Clear the maximum distance |
| status_o | output | 64 | Packed status word |
| dist_total_o | output | TOT_W | Sum of distances |
| dist_samples_o | output | TOT_W | Number of distance samples |
| dist_max_o | output | DIST_W | Largest distance since reset or clear |

## Verification
The assertions assume a legal event stream. A copy-done only arrives for a channel that is both busy and mapped. A map only targets a channel that holds no packet. No channel sees more than one of the three per-channel strobes in a cycle. Under these assumptions a blocking head channel always implies a nonzero dirty count. The random stimulus keeps a shadow copy of each channel's busy and mapped bits and draws every strobe's channel from the set that is legal in that cycle. The directed saturation run sends only descriptor writes, plus a single legal copy at the ceiling.

// File: rtl/rxvc_pkg.sv
package rxvc_pkg;
  localparam int FIELD_W = 16;
  typedef logic [FIELD_W-1:0] cnt_t;
  localparam cnt_t CNT_MAX   = {FIELD_W{1'b1}};
  localparam cnt_t HEAD_NONE = {FIELD_W{1'b1}};

  // one-step saturating counter update: +1, -1 or hold
  function automatic cnt_t sat_step(input cnt_t c, input logic up, input logic dn);
    cnt_t r;
    r = c;
    if (up && !dn && c != CNT_MAX)
      r = c + 1'b1;
    else if (dn && !up && c != '0)
      r = c - 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/rxvc_chan_table.sv
module rxvc_chan_table import rxvc_pkg::*; #(
  parameter int NCH   = 8,
  parameter int LEN_W = 20,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_wr,
  input  logic [CH_W-1:0]  desc_ch,
  input  logic             map_v,
  input  logic [CH_W-1:0]  map_ch,
  input  logic             done_v,
  input  logic [CH_W-1:0]  done_ch,
  input  logic             done_full,
  input  logic [LEN_W-1:0] done_len,
  input  logic             head_v,
  input  logic [CH_W-1:0]  head_ch,
  output logic             done_off_zero,
  output cnt_t             head_field
);
  logic [NCH-1:0][LEN_W-1:0] off_q, off_nxt;
  logic [NCH-1:0]            busy_q, busy_nxt, mapped_q, mapped_nxt;
  logic                      head_v_q;
  logic [CH_W-1:0]           head_ch_q;
  logic [LEN_W-1:0]          adv_len;
  logic                      head_blocked;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic map_hit, done_hit, desc_hit;
    assign map_hit  = map_v   && (map_ch  == CH_W'(g));
    assign done_hit = done_v  && (done_ch == CH_W'(g));
    assign desc_hit = desc_wr && (desc_ch == CH_W'(g));
    assign off_nxt[g] = map_hit  ? '0 :
                        done_hit ? (done_full ? '0 : off_q[g] + done_len) :
                        off_q[g];
    assign busy_nxt[g]   = desc_hit ? 1'b1 : (done_hit ? 1'b0 : busy_q[g]);
    assign mapped_nxt[g] = map_hit ? 1'b1 : ((done_hit && done_full) ? 1'b0 : mapped_q[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q     <= '0;
      busy_q    <= '0;
      mapped_q  <= '0;
      head_v_q  <= 1'b0;
      head_ch_q <= '0;
    end else begin
      off_q     <= off_nxt;
      busy_q    <= busy_nxt;
      mapped_q  <= mapped_nxt;
      head_v_q  <= head_v;
      head_ch_q <= head_ch;
    end
  end

  assign adv_len       = off_q[done_ch] + done_len;
  assign done_off_zero = (off_q[done_ch] == '0);
  assign head_blocked  = head_v_q && (off_q[head_ch_q] != '0);
  assign head_field    = head_blocked ? FIELD_W'(head_ch_q) : HEAD_NONE;

  // input legality the other checks rely on (R2, R3)
  p_done_on_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_v |-> (busy_q[done_ch] && mapped_q[done_ch]));
  p_map_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    map_v |-> !mapped_q[map_ch]);
  p_map_zero_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    map_v |=> off_q[$past(map_ch)] == '0);
  p_full_zero_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_v && done_full) |=> off_q[$past(done_ch)] == '0);
  p_partial_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_v && !done_full) |=> off_q[$past(done_ch)] == $past(adv_len));
endmodule

// File: rtl/rxvc_counters.sv
module rxvc_counters import rxvc_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic desc_wr,
  input  logic map_v,
  input  logic done_v,
  input  logic done_full,
  input  logic done_off_zero,
  output cnt_t busy_o,
  output cnt_t mapped_o,
  output cnt_t dirty_o
);
  cnt_t busy_q, mapped_q, dirty_q;
  logic dirty_up, dirty_dn, mapped_dn;

  // named events: first partial copy makes a channel dirty, a full copy of
  // a dirty channel cleans it
  assign dirty_up  = done_v && !done_full && done_off_zero;
  assign dirty_dn  = done_v && done_full && !done_off_zero;
  assign mapped_dn = done_v && done_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= '0;
      mapped_q <= '0;
      dirty_q  <= '0;
    end else begin
      busy_q   <= sat_step(busy_q, desc_wr, done_v);
      mapped_q <= sat_step(mapped_q, map_v, mapped_dn);
      dirty_q  <= sat_step(dirty_q, dirty_up, dirty_dn);
    end
  end

  assign busy_o   = busy_q;
  assign mapped_o = mapped_q;
  assign dirty_o  = dirty_q;

  p_busy_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr && !done_v && busy_q != CNT_MAX) |=> busy_q == $past(busy_q) + 1'b1);
  p_mapped_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_v && done_full && !map_v && mapped_q != '0) |=> mapped_q == $past(mapped_q) - 1'b1);
  p_dirty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_v && !done_full && !done_off_zero) |=> $stable(dirty_q));
  p_busy_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q == CNT_MAX) |=> busy_q != '0);
endmodule

// File: rtl/rxvc_dist_stats.sv
module rxvc_dist_stats #(
  parameter int DIST_W = 16,
  parameter int TOT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sched_v,
  input  logic [DIST_W-1:0] sched_dist,
  input  logic              stat_clr,
  output logic [TOT_W-1:0]  total_o,
  output logic [TOT_W-1:0]  samples_o,
  output logic [DIST_W-1:0] max_o
);
  localparam logic [TOT_W-1:0] TOT_MAX = {TOT_W{1'b1}};
  localparam logic [TOT_W-1:0] TOT_ONE = {{(TOT_W-1){1'b0}}, 1'b1};

  function automatic logic [TOT_W-1:0] sat_add(input logic [TOT_W-1:0] a,
                                               input logic [TOT_W-1:0] b);
    logic [TOT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[TOT_W] ? TOT_MAX : s[TOT_W-1:0];
  endfunction

  logic [TOT_W-1:0]  total_q, samples_q;
  logic [DIST_W-1:0] max_q;
  logic              new_peak;

  assign new_peak = sched_v && (stat_clr || sched_dist > max_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q   <= '0;
      samples_q <= '0;
      max_q     <= '0;
    end else begin
      if (sched_v) begin
        total_q   <= sat_add(total_q, TOT_W'(sched_dist));
        samples_q <= sat_add(samples_q, TOT_ONE);
      end
      if (new_peak)      max_q <= sched_dist;
      else if (stat_clr) max_q <= '0;
    end
  end

  assign total_o   = total_q;
  assign samples_o = samples_q;
  assign max_o     = max_q;

  p_samples_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_v && samples_q != TOT_MAX) |=> samples_q == $past(samples_q) + TOT_ONE);
  p_max_covers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sched_v |=> max_q >= $past(sched_dist));
  p_clear_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !sched_v) |=> max_q == '0);
endmodule

// File: rtl/rx_vc_tracker.sv
module rx_vc_tracker import rxvc_pkg::*; #(
  parameter int NCH    = 8,
  parameter int LEN_W  = 20,
  parameter int DIST_W = 16,
  parameter int TOT_W  = 32,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_wr_i,
  input  logic [CH_W-1:0]   desc_ch_i,
  input  logic              map_i,
  input  logic [CH_W-1:0]   map_ch_i,
  input  logic              done_i,
  input  logic [CH_W-1:0]   done_ch_i,
  input  logic              done_full_i,
  input  logic [LEN_W-1:0]  done_len_i,
  input  logic              head_vld_i,
  input  logic [CH_W-1:0]   head_ch_i,
  input  logic              sched_i,
  input  logic [DIST_W-1:0] sched_dist_i,
  input  logic              stat_clr_i,
  output logic [63:0]       status_o,
  output logic [TOT_W-1:0]  dist_total_o,
  output logic [TOT_W-1:0]  dist_samples_o,
  output logic [DIST_W-1:0] dist_max_o
);
  logic done_off_zero;
  cnt_t head_field, busy_cnt, mapped_cnt, dirty_cnt;

  rxvc_chan_table #(.NCH(NCH), .LEN_W(LEN_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .desc_wr(desc_wr_i), .desc_ch(desc_ch_i),
    .map_v(map_i), .map_ch(map_ch_i),
    .done_v(done_i), .done_ch(done_ch_i), .done_full(done_full_i), .done_len(done_len_i),
    .head_v(head_vld_i), .head_ch(head_ch_i),
    .done_off_zero(done_off_zero), .head_field(head_field)
  );

  rxvc_counters u_counters (
    .clk(clk), .rst_n(rst_n),
    .desc_wr(desc_wr_i), .map_v(map_i), .done_v(done_i), .done_full(done_full_i),
    .done_off_zero(done_off_zero),
    .busy_o(busy_cnt), .mapped_o(mapped_cnt), .dirty_o(dirty_cnt)
  );

  rxvc_dist_stats #(.DIST_W(DIST_W), .TOT_W(TOT_W)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .sched_v(sched_i), .sched_dist(sched_dist_i), .stat_clr(stat_clr_i),
    .total_o(dist_total_o), .samples_o(dist_samples_o), .max_o(dist_max_o)
  );

  assign status_o = {dirty_cnt, mapped_cnt, busy_cnt, head_field};

  // a channel can only block the head while it is counted as dirty (R7)
  p_head_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[15:0] != HEAD_NONE) |-> (status_o[63:48] != '0));
endmodule

// File: tb/rx_vc_tracker_bench.sv
module rx_vc_tracker_bench;
  localparam int NCH = 8, LEN_W = 20, DIST_W = 16, TOT_W = 32, CH_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_wr_i, map_i, done_i, done_full_i, head_vld_i, sched_i, stat_clr_i;
  logic [CH_W-1:0] desc_ch_i, map_ch_i, done_ch_i, head_ch_i;
  logic [LEN_W-1:0] done_len_i;
  logic [DIST_W-1:0] sched_dist_i;
  logic [63:0] status_o;
  logic [TOT_W-1:0] dist_total_o, dist_samples_o;
  logic [DIST_W-1:0] dist_max_o;

  rx_vc_tracker #(.NCH(NCH), .LEN_W(LEN_W), .DIST_W(DIST_W), .TOT_W(TOT_W)) u_rx_vc_tracker (
    .clk(clk), .rst_n(rst_n),
    .desc_wr_i(desc_wr_i), .desc_ch_i(desc_ch_i), .map_i(map_i), .map_ch_i(map_ch_i),
    .done_i(done_i), .done_ch_i(done_ch_i), .done_full_i(done_full_i), .done_len_i(done_len_i),
    .head_vld_i(head_vld_i), .head_ch_i(head_ch_i), .sched_i(sched_i),
    .sched_dist_i(sched_dist_i), .stat_clr_i(stat_clr_i), .status_o(status_o),
    .dist_total_o(dist_total_o), .dist_samples_o(dist_samples_o), .dist_max_o(dist_max_o)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  // shadow model
  int m_busy, m_mapped, m_dirty, m_head, m_max;
  longint m_tot, m_smp;
  bit mb[NCH], mm[NCH];
  int moff[NCH];

  function automatic int clamp16(int v);
    return (v < 0) ? 0 : ((v > 65535) ? 65535 : v);
  endfunction

  function automatic longint clamp32(longint v);
    return (v > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : v;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    desc_wr_i = 0; map_i = 0; done_i = 0; done_full_i = 0; head_vld_i = 0;
    sched_i = 0; stat_clr_i = 0; desc_ch_i = 0; map_ch_i = 0; done_ch_i = 0;
    head_ch_i = 0; done_len_i = 0; sched_dist_i = 0;
  endtask

  task automatic model_reset();
    m_busy = 0; m_mapped = 0; m_dirty = 0; m_head = 'hFFFF; m_max = 0; m_tot = 0; m_smp = 0;
    for (int i = 0; i < NCH; i++) begin mb[i] = 0; mm[i] = 0; moff[i] = 0; end
  endtask

  task automatic model_step();
    int dd;
    dd = 0;
    if (done_i) begin
      if (done_full_i) begin
        if (moff[done_ch_i] != 0) dd = -1;
        moff[done_ch_i] = 0; mm[done_ch_i] = 0;
      end else begin
        if (moff[done_ch_i] == 0) dd = 1;
        moff[done_ch_i] = (moff[done_ch_i] + int'(done_len_i)) & 'hFFFFF;
      end
      mb[done_ch_i] = 0;
    end
    if (map_i) begin mm[map_ch_i] = 1; moff[map_ch_i] = 0; end
    if (desc_wr_i) mb[desc_ch_i] = 1;
    m_busy   = clamp16(m_busy + int'(desc_wr_i) - int'(done_i));
    m_mapped = clamp16(m_mapped + int'(map_i) - int'(done_i && done_full_i));
    m_dirty  = clamp16(m_dirty + dd);
    m_head   = (head_vld_i && moff[head_ch_i] != 0) ? int'(head_ch_i) : 'hFFFF;
    if (sched_i) begin
      m_tot = clamp32(m_tot + longint'(sched_dist_i));
      m_smp = clamp32(m_smp + 1);
    end
    if (stat_clr_i) m_max = 0;
    if (sched_i && int'(sched_dist_i) > m_max) m_max = int'(sched_dist_i);
  endtask

  task automatic compare_all();
    chk("R2 busy", 64'(status_o[31:16]), 64'(m_busy));
    chk("R3 R4 mapped", 64'(status_o[47:32]), 64'(m_mapped));
    chk("R5 dirty", 64'(status_o[63:48]), 64'(m_dirty));
    chk("R7 head", 64'(status_o[15:0]), 64'(m_head));
    chk("R8 total", 64'(dist_total_o), 64'(m_tot));
    chk("R8 samples", 64'(dist_samples_o), 64'(m_smp));
    chk("R9 max", 64'(dist_max_o), 64'(m_max));
  endtask

  // inputs are set by the caller after a negedge; result is visible 1 ns after the edge
  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic rand_cycle();
    int r, dch, mch;
    @(negedge clk);
    idle();
    dch = -1; mch = -1;
    r = $urandom % NCH;
    if ($urandom % 10 < 5)
      for (int k = 0; k < NCH; k++) begin
        int c;
        c = (r + k) % NCH;
        if (mb[c] && mm[c]) begin dch = c; break; end
      end
    if (dch >= 0) begin
      done_i = 1; done_ch_i = CH_W'(dch); done_full_i = ($urandom % 2 == 0);
      done_len_i = LEN_W'(1 + $urandom % 255);
    end
    r = $urandom % NCH;
    if ($urandom % 10 < 4)
      for (int k = 0; k < NCH; k++) begin
        int c;
        c = (r + k) % NCH;
        if (!mm[c] && c != dch) begin mch = c; break; end
      end
    if (mch >= 0) begin map_i = 1; map_ch_i = CH_W'(mch); end
    if ($urandom % 10 < 4) begin
      int c;
      c = $urandom % NCH;
      while (c == dch || c == mch) c = (c + 1) % NCH;
      desc_wr_i = 1; desc_ch_i = CH_W'(c);
    end
    head_vld_i = ($urandom % 4 != 0);
    head_ch_i = CH_W'($urandom % NCH);
    sched_i = ($urandom % 3 == 0);
    sched_dist_i = DIST_W'($urandom % 300);
    stat_clr_i = ($urandom % 30 == 0);
    tick();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    idle();
    do_reset();
    #1;
    // R1: reset values
    chk("R1 status", status_o, 64'h0000_0000_0000_FFFF);
    chk("R1 total", 64'(dist_total_o), 64'd0);
    chk("R1 max", 64'(dist_max_o), 64'd0);

    // directed partial/full copy sequence on channel 3
    @(negedge clk); idle(); desc_wr_i = 1; desc_ch_i = 3; tick();
    chk("R2 busy after desc", 64'(status_o[31:16]), 64'd1);
    @(negedge clk); idle(); map_i = 1; map_ch_i = 3; head_vld_i = 1; head_ch_i = 3; tick();
    chk("R3 mapped after map", 64'(status_o[47:32]), 64'd1);
    chk("R7 head none at zero offset", 64'(status_o[15:0]), 64'hFFFF);
    @(negedge clk); idle(); done_i = 1; done_ch_i = 3; done_len_i = 100;
    head_vld_i = 1; head_ch_i = 3; tick();
    chk("R5 first partial dirty", 64'(status_o[63:48]), 64'd1);
    chk("R6 packed word", status_o, 64'h0001_0001_0000_0003);
    @(negedge clk); idle(); desc_wr_i = 1; desc_ch_i = 3; tick();
    @(negedge clk); idle(); done_i = 1; done_ch_i = 3; done_len_i = 50; tick();
    chk("R5 second partial no recount", 64'(status_o[63:48]), 64'd1);
    @(negedge clk); idle(); desc_wr_i = 1; desc_ch_i = 3; tick();
    @(negedge clk); idle(); done_i = 1; done_ch_i = 3; done_full_i = 1; done_len_i = 20;
    head_vld_i = 1; head_ch_i = 3; tick();
    chk("R4 mapped after full", 64'(status_o[47:32]), 64'd0);
    chk("R4 dirty after full", 64'(status_o[63:48]), 64'd0);
    chk("R7 head clears after full", 64'(status_o[15:0]), 64'hFFFF);

    // R11: concurrent events on distinct channels
    @(negedge clk); idle(); desc_wr_i = 1; desc_ch_i = 1; tick();
    @(negedge clk); idle(); desc_wr_i = 1; desc_ch_i = 2; map_i = 1; map_ch_i = 2; tick();
    @(negedge clk); idle(); desc_wr_i = 1; desc_ch_i = 5; done_i = 1; done_ch_i = 2;
    done_full_i = 1; done_len_i = 64; map_i = 1; map_ch_i = 6; tick();
    chk("R11 busy combined", 64'(status_o[31:16]), 64'd2);
    chk("R11 mapped combined", 64'(status_o[47:32]), 64'd1);

    // R8 / R9 statistics
    @(negedge clk); idle(); sched_i = 1; sched_dist_i = 40; tick();
    @(negedge clk); idle(); sched_i = 1; sched_dist_i = 10; tick();
    chk("R8 max kept", 64'(dist_max_o), 64'd40);
    chk("R8 total", 64'(dist_total_o), 64'd50);
    @(negedge clk); idle(); stat_clr_i = 1; tick();
    chk("R9 max cleared", 64'(dist_max_o), 64'd0);
    chk("R9 total kept", 64'(dist_total_o), 64'd50);
    chk("R9 samples kept", 64'(dist_samples_o), 64'd2);
    @(negedge clk); idle(); stat_clr_i = 1; sched_i = 1; sched_dist_i = 7; tick();
    chk("R9 clear with sample", 64'(dist_max_o), 64'd7);

    // constrained random
    for (int n = 0; n < 3000; n++) rand_cycle();

    // R10 saturation of the busy count
    do_reset();
    for (int n = 0; n < 65540; n++) begin
      @(negedge clk); idle(); desc_wr_i = 1; desc_ch_i = CH_W'(n % NCH); tick();
    end
    chk("R10 busy saturated", 64'(status_o[31:16]), 64'hFFFF);
    @(negedge clk); idle(); map_i = 1; map_ch_i = 1; tick();
    @(negedge clk); idle(); done_i = 1; done_ch_i = 1; done_full_i = 1; done_len_i = 8;
    desc_wr_i = 1; desc_ch_i = 0; tick();
    chk("R10 R11 busy held at ceiling", 64'(status_o[31:16]), 64'hFFFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule